// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out block push and block pop operations between an eight-entry register file of 16-bit words and a synchronous data memory. A decoder outside the block supplies a one-cycle start pulse with the decoded fields. These are the direction, a base register field, a transfer count, the index of the register that serves as stack pointer, and a flag that adds the hidden interrupt-flags word to the transfer. The block then moves one word per cycle. It writes the final stack pointer back into the chosen register and signals completion with a single-cycle done pulse.

The register file and the memory live outside the block. The block reads registers through one combinational read port and writes them through one write port. It updates the flags word through its own write strobe. It reaches memory through a port whose read data arrives on the cycle after the request. A return-from-call is a pop of two registers starting above register 5 with register 0 as stack pointer. A return-from-interrupt is the same pop with a count of three and the flags word included. Any register may act as the stack pointer.

The controller is a five-state machine. IDLE waits for start and takes the transition "accept" to LOAD, or the transition "empty" straight to WBACK when the count is zero. LOAD reads the stack pointer register and takes "begin" to XFER. XFER makes one memory access per cycle. On the last item it takes "tail" to DRAIN for a pop or "finish" to WBACK for a push. DRAIN lands the last popped word and takes "close" to WBACK. WBACK writes the stack pointer, raises done and takes "release" back to IDLE.

Top module: `pp_stack_seq`

## Requirements
- R1: After reset, busy, done, mem_en, rf_we and flags_we are all low.
- R2: A start pulse is accepted only while busy is low. A start pulse while busy is high has no effect on the running operation, on memory, on registers or on the access count.
- R3: A push of count N makes N memory writes on N consecutive cycles. The first write goes to the current stack pointer address and each later write goes one address lower. With the flags word included, it is written first. The registers follow from index base+R down to base+1, where R is the number of registers. Register indices are taken modulo 8.
- R4: A pop of count N makes N memory reads at stack pointer +1, +2, … +N. It restores registers base+1, base+2, … (modulo 8) in ascending order. Each word is written into the register file on the cycle after its read.
- R5: The final stack pointer is the old value minus N for a push and plus N for a pop, modulo 2^16. It is written into the stack-pointer register in the done cycle, so it overrides any word popped into that same register.
- R6: A count of 0 raises done on the cycle after start, with no memory access, no register or flags write, and the stack pointer unchanged.
- R7: done is high for exactly one cycle. For N>0 it is high in cycle N+2 after the start edge for a push and in cycle N+3 for a pop.
- R8: With the flags flag set and N>0, the flags word counts as one of the N items, so N-1 registers are transferred. On a pop the flags word is restored last through flags_we. Base 5, count 3, stack pointer 0 with flags restores R6, R7 and the flags word. Base 5, count 2 without flags restores R6 and R7.
- R9: Any of the eight registers can be the stack pointer, and stack addresses wrap through 0x0000/0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request carrying the fields below |
| op_pop | input | 1 | 1 = pop, 0 = push |
| base_reg | input | 3 | Base register field; first register is base_reg+1 |
| xfer_cnt | input | 3 | Number of items to move |
| sp_sel | input | 3 | Index of the stack-pointer register |
| with_flags | input | 1 | Include the interrupt-flags word |
| busy | output | 1 | High from the cycle after acceptance through done |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| flags_in | input | 16 | Current interrupt-flags word |
| flags_we | output | 1 | Flags word write strobe |
| flags_wdata | output | 16 | Flags word write data |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read |

## Verification
The bench builds the block with its defaults: 16-bit words, eight registers and a 3-bit count. Every count from 0 to 7 is therefore reachable, including a pop that covers the stack-pointer register itself. A 16-bit stack pointer lets a directed case start a push at address 1 and cross through 0xFFFF and back. A count field as wide as the register index allows ranges that wrap past register 7 into register 0, and random cases reach them.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_XFER  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_WBACK = 3'd4
    } seq_state_e;

endpackage

// File: rtl/pp_fsm.sv
module pp_fsm
    import pp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cnt_zero,
    input  logic       is_pop,
    input  logic       last_step,
    output seq_state_e state,
    output logic       do_load,
    output logic       do_xfer,
    output logic       do_wback
);

    seq_state_e state_q;
    seq_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, empty, begin, tail, finish, close, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = cnt_zero ? ST_WBACK : ST_LOAD;
                end
            end
            ST_LOAD:  state_d = ST_XFER;
            ST_XFER: begin
                if (last_step) begin
                    state_d = is_pop ? ST_DRAIN : ST_WBACK;
                end
            end
            ST_DRAIN: state_d = ST_WBACK;
            ST_WBACK: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // decoded outputs
    always_comb begin
        do_load  = 1'b0;
        do_xfer  = 1'b0;
        do_wback = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOAD:  do_load  = 1'b1;
            ST_XFER:  do_xfer  = 1'b1;
            ST_DRAIN: ;
            ST_WBACK: do_wback = 1'b1;
            default:  ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pp_item_map.sv
module pp_item_map #(
    parameter int RIW = 3,
    parameter int CW  = 3
) (
    input  logic           is_pop,
    input  logic           incl_flags,
    input  logic [RIW-1:0] base,
    input  logic [CW-1:0]  count,
    input  logic [CW-1:0]  step,
    output logic           item_flags,
    output logic [RIW-1:0] item_idx
);

    localparam int SW = ((CW > RIW) ? CW : RIW) + 1;

    logic [SW-1:0] base_w;
    logic [SW-1:0] cnt_w;
    logic [SW-1:0] step_w;
    logic [SW-1:0] reg_cnt;
    logic [SW-1:0] sum_w;

    always_comb begin
        base_w  = SW'(base);
        cnt_w   = SW'(count);
        step_w  = SW'(step);
        reg_cnt = cnt_w - SW'(incl_flags);
        if (is_pop) begin
            // ascending registers, flags word last
            item_flags = (step_w >= reg_cnt);
            sum_w      = base_w + SW'(1) + step_w;
        end else begin
            // flags word first, then descending registers
            item_flags = incl_flags && (step == '0);
            sum_w      = base_w + cnt_w - step_w;
        end
        item_idx = sum_w[RIW-1:0];
    end

endmodule

// File: rtl/pp_sp_unit.sv
module pp_sp_unit #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          step,
    input  logic          is_pop,
    output logic [DW-1:0] sp_val,
    output logic [DW-1:0] acc_addr
);

    logic [DW-1:0] sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= load_val;
        end else if (step) begin
            sp_q <= is_pop ? (sp_q + DW'(1)) : (sp_q - DW'(1));
        end
    end

    // push: write then post-decrement; pop: pre-increment then read
    assign acc_addr = is_pop ? (sp_q + DW'(1)) : sp_q;
    assign sp_val   = sp_q;

endmodule

// File: rtl/pp_stack_seq.sv
module pp_stack_seq
    import pp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int CW   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    op_pop,
    input  logic [$clog2(NREG)-1:0] base_reg,
    input  logic [CW-1:0]           xfer_cnt,
    input  logic [$clog2(NREG)-1:0] sp_sel,
    input  logic                    with_flags,
    output logic                    busy,
    output logic                    done,
    output logic [$clog2(NREG)-1:0] rf_raddr,
    input  logic [DW-1:0]           rf_rdata,
    output logic                    rf_we,
    output logic [$clog2(NREG)-1:0] rf_waddr,
    output logic [DW-1:0]           rf_wdata,
    input  logic [DW-1:0]           flags_in,
    output logic                    flags_we,
    output logic [DW-1:0]           flags_wdata,
    output logic                    mem_en,
    output logic                    mem_we,
    output logic [DW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata
);

    localparam int RIW = $clog2(NREG);

    seq_state_e     st;
    logic           do_load;
    logic           do_xfer;
    logic           do_wback;
    logic           accept;
    logic           last_step;

    logic           op_pop_q;
    logic           flags_q;
    logic [RIW-1:0] base_q;
    logic [RIW-1:0] spsel_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  step_q;
    logic           incl_flags;

    logic           item_flags;
    logic [RIW-1:0] item_idx;
    logic [DW-1:0]  sp_val;
    logic [DW-1:0]  acc_addr;

    logic           pend_q;
    logic           pend_flags_q;
    logic [RIW-1:0] pend_idx_q;

    assign accept     = start && (st == ST_IDLE);
    assign last_step  = (step_q == (cnt_q - CW'(1)));
    assign incl_flags = flags_q && (cnt_q != '0);

    pp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cnt_zero  (xfer_cnt == '0),
        .is_pop    (op_pop_q),
        .last_step (last_step),
        .state     (st),
        .do_load   (do_load),
        .do_xfer   (do_xfer),
        .do_wback  (do_wback)
    );

    pp_item_map #(
        .RIW (RIW),
        .CW  (CW)
    ) u_map (
        .is_pop     (op_pop_q),
        .incl_flags (incl_flags),
        .base       (base_q),
        .count      (cnt_q),
        .step       (step_q),
        .item_flags (item_flags),
        .item_idx   (item_idx)
    );

    pp_sp_unit #(
        .DW (DW)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .load_val (rf_rdata),
        .step     (do_xfer),
        .is_pop   (op_pop_q),
        .sp_val   (sp_val),
        .acc_addr (acc_addr)
    );

    // field capture and item counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_pop_q <= 1'b0;
            flags_q  <= 1'b0;
            base_q   <= '0;
            spsel_q  <= '0;
            cnt_q    <= '0;
            step_q   <= '0;
        end else if (accept) begin
            op_pop_q <= op_pop;
            flags_q  <= with_flags;
            base_q   <= base_reg;
            spsel_q  <= sp_sel;
            cnt_q    <= xfer_cnt;
            step_q   <= '0;
        end else if (do_xfer) begin
            step_q   <= step_q + CW'(1);
        end
    end

    // pop read pipeline: the word lands one cycle after its read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_flags_q <= 1'b0;
            pend_idx_q   <= '0;
        end else begin
            pend_q       <= do_xfer && op_pop_q;
            pend_flags_q <= item_flags;
            pend_idx_q   <= item_idx;
        end
    end

    assign rf_raddr    = do_load ? spsel_q : item_idx;
    assign mem_en      = do_xfer;
    assign mem_we      = do_xfer && !op_pop_q;
    assign mem_addr    = acc_addr;
    assign mem_wdata   = item_flags ? flags_in : rf_rdata;

    assign rf_we       = (pend_q && !pend_flags_q) || (do_wback && (cnt_q != '0));
    assign rf_waddr    = do_wback ? spsel_q : pend_idx_q;
    assign rf_wdata    = do_wback ? sp_val : mem_rdata;
    assign flags_we    = pend_q && pend_flags_q;
    assign flags_wdata = mem_rdata;

    assign busy        = (st != ST_IDLE);
    assign done        = do_wback;

    // R2: captured fields hold while an operation runs
    a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(base_q) && $stable(cnt_q) && $stable(spsel_q) && $stable(op_pop_q)));

    // R3: back-to-back push writes walk down by one
    a_r3_push_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && $past(mem_en && mem_we)) |-> (mem_addr == $past(mem_addr) - DW'(1)));

    // R4: back-to-back pop reads walk up by one
    a_r4_pop_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && $past(mem_en && !mem_we)) |-> (mem_addr == $past(mem_addr) + DW'(1)));

    // R4: a restore only ever follows a memory read
    a_r4_restore_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we || (rf_we && !done)) |-> $past(mem_en && !mem_we));

    // R6: a zero count finishes next cycle without touching memory
    a_r6_empty_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start && xfer_cnt == '0) |=> (done && !mem_en));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: flags and register writes never share a cycle
    a_r8_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && flags_we));

endmodule

// File: tb/pp_stack_seq_tb.sv
`timescale 1ns/1ps
module pp_stack_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_pop = 1'b0;
    logic [2:0]  base_reg = '0;
    logic [2:0]  xfer_cnt = '0;
    logic [2:0]  sp_sel = '0;
    logic        with_flags = 1'b0;
    logic        busy, done;
    logic [2:0]  rf_raddr, rf_waddr;
    logic [15:0] rf_rdata, rf_wdata;
    logic        rf_we, flags_we;
    logic [15:0] flags_in, flags_wdata;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    // host-side writes into the environment (only while idle)
    logic        h_rwe = 1'b0;
    logic        h_fwe = 1'b0;
    logic        h_clr = 1'b0;
    logic [2:0]  h_idx = '0;
    logic [15:0] h_val = '0;

    logic [15:0] env_rf [8];
    logic [15:0] env_mem [256];
    logic [15:0] env_flags;
    logic [15:0] rdata_q;
    int          acc_cnt;

    logic [15:0] exp_rf [8];
    logic [15:0] exp_mem [256];
    logic [15:0] exp_flags;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pp_stack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_pop(op_pop),
        .base_reg(base_reg), .xfer_cnt(xfer_cnt), .sp_sel(sp_sel),
        .with_flags(with_flags), .busy(busy), .done(done),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .flags_in(flags_in),
        .flags_we(flags_we), .flags_wdata(flags_wdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] pat(int i);
        return 16'((i * 40503) ^ 16'h5A5A);
    endfunction

    assign rf_rdata  = env_rf[rf_raddr];
    assign flags_in  = env_flags;
    assign mem_rdata = rdata_q;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) env_rf[i] <= pat(i + 300);
            for (int i = 0; i < 256; i++) env_mem[i] <= pat(i);
            env_flags <= 16'hF1A9;
            rdata_q   <= '0;
            acc_cnt   <= 0;
        end else begin
            if (h_rwe) env_rf[h_idx] <= h_val;
            if (h_fwe) env_flags <= h_val;
            if (rf_we) env_rf[rf_waddr] <= rf_wdata;
            if (flags_we) env_flags <= flags_wdata;
            if (mem_en) begin
                if (mem_we) env_mem[mem_addr[7:0]] <= mem_wdata;
                else        rdata_q <= env_mem[mem_addr[7:0]];
            end
            if (h_clr)       acc_cnt <= 0;
            else if (mem_en) acc_cnt <= acc_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host_rf(input logic [2:0] idx, input logic [15:0] val);
        @(negedge clk);
        h_rwe = 1'b1; h_idx = idx; h_val = val;
        @(negedge clk);
        h_rwe = 1'b0;
        exp_rf[idx] = val;
    endtask

    task automatic host_flags(input logic [15:0] val);
        @(negedge clk);
        h_fwe = 1'b1; h_val = val;
        @(negedge clk);
        h_fwe = 1'b0;
        exp_flags = val;
    endtask

    // behavioural model built from R3, R4, R5, R8
    task automatic model(input bit pop, input logic [2:0] a, input logic [2:0] n,
                         input logic [2:0] b, input bit wf);
        logic [15:0] sp;
        int f, r;
        sp = exp_rf[b];
        f  = (wf && n != 0) ? 1 : 0;
        r  = int'(n) - f;
        for (int k = 0; k < int'(n); k++) begin
            if (!pop) begin
                if (f == 1 && k == 0) exp_mem[sp[7:0]] = exp_flags;
                else exp_mem[sp[7:0]] = exp_rf[3'(int'(a) + r - (k - f))];
                sp = sp - 16'd1;
            end else begin
                sp = sp + 16'd1;
                if (k < r) exp_rf[3'(int'(a) + 1 + k)] = exp_mem[sp[7:0]];
                else exp_flags = exp_mem[sp[7:0]];
            end
        end
        if (n != 0) exp_rf[b] = sp;
    endtask

    task automatic run_op(input bit pop, input logic [2:0] a, input logic [2:0] n,
                          input logic [2:0] b, input bit wf, input bit poke, input string tag);
        int lat, exp_lat, bad_i;
        bit ok;
        model(pop, a, n, b, wf);
        exp_lat = (n == 0) ? 1 : (pop ? int'(n) + 3 : int'(n) + 2);
        @(negedge clk);
        op_pop = pop; base_reg = a; xfer_cnt = n; sp_sel = b; with_flags = wf;
        start = 1'b1; h_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; h_clr = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            if (poke && lat == 1) begin
                // R2: a second request while busy
                start = 1'b1; op_pop = 1'b0; xfer_cnt = 3'd7; sp_sel = 3'd5; base_reg = 3'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat == exp_lat, (n == 0) ? "R6" : "R7", {tag, " done latency"}, lat, exp_lat);
        @(negedge clk);
        check(!done && !busy, "R7", {tag, " done single pulse"}, {done, busy}, 0);
        ok = 1'b1; bad_i = 0;
        for (int i = 0; i < 8; i++) if (env_rf[i] !== exp_rf[i] && ok) begin ok = 1'b0; bad_i = i; end
        check(ok, "R4 R5", {tag, " register file"}, env_rf[bad_i], exp_rf[bad_i]);
        check(env_flags === exp_flags, "R8", {tag, " flags word"}, env_flags, exp_flags);
        ok = 1'b1; bad_i = 0;
        for (int i = 0; i < 256; i++) if (env_mem[i] !== exp_mem[i] && ok) begin ok = 1'b0; bad_i = i; end
        check(ok, "R3", {tag, " memory image"}, env_mem[bad_i], exp_mem[bad_i]);
        check(acc_cnt == int'(n), "R2", {tag, " memory access count"}, acc_cnt, n);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v6, v7, vf;
        void'($urandom(32'h2468ACE1));
        for (int i = 0; i < 8; i++) exp_rf[i] = pat(i + 300);
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
        exp_flags = 16'hF1A9;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(!busy && !done && !mem_en && !rf_we && !flags_we, "R1", "reset outputs",
              {busy, done, mem_en, rf_we, flags_we}, 0);

        // R6: zero counts, with and without the flags flag
        run_op(1'b0, 3'd3, 3'd0, 3'd2, 1'b0, 1'b0, "R6 push zero");
        run_op(1'b1, 3'd3, 3'd0, 3'd2, 1'b1, 1'b0, "R6 pop zero");

        // R9: stack crossing address zero in both directions
        host_rf(3'd4, 16'h0001);
        run_op(1'b0, 3'd1, 3'd3, 3'd4, 1'b0, 1'b0, "R9 push wrap");
        check(env_rf[4] === 16'hFFFE, "R9", "sp after wrapping push", env_rf[4], 16'hFFFE);
        run_op(1'b1, 3'd1, 3'd3, 3'd4, 1'b0, 1'b0, "R9 pop wrap");
        check(env_rf[4] === 16'h0001, "R9", "sp after wrapping pop", env_rf[4], 16'h0001);

        // R8: interrupt-style save, clobber, then return with flags
        host_rf(3'd0, 16'h0040);
        host_rf(3'd6, 16'hA6A6);
        host_rf(3'd7, 16'hB7B7);
        host_flags(16'h00C3);
        v6 = 16'hA6A6; v7 = 16'hB7B7; vf = 16'h00C3;
        run_op(1'b0, 3'd5, 3'd3, 3'd0, 1'b1, 1'b0, "R8 save with flags");
        host_rf(3'd6, 16'h1111);
        host_rf(3'd7, 16'h2222);
        host_flags(16'h3333);
        run_op(1'b1, 3'd5, 3'd3, 3'd0, 1'b1, 1'b0, "R8 interrupt return");
        check(env_rf[6] === v6, "R8", "interrupt return R6", env_rf[6], v6);
        check(env_rf[7] === v7, "R8", "interrupt return R7", env_rf[7], v7);
        check(env_flags === vf, "R8", "interrupt return flags", env_flags, vf);
        check(env_rf[0] === 16'h0040, "R8", "interrupt return sp", env_rf[0], 16'h0040);

        // R8: call-style return, flags untouched
        run_op(1'b0, 3'd5, 3'd2, 3'd0, 1'b0, 1'b0, "R8 save call frame");
        host_rf(3'd6, 16'h4444);
        host_rf(3'd7, 16'h5555);
        run_op(1'b1, 3'd5, 3'd2, 3'd0, 1'b0, 1'b0, "R8 call return");
        check(env_rf[6] === v6 && env_rf[7] === v7, "R8", "call return R6 R7",
              {env_rf[6], env_rf[7]}, {v6, v7});
        check(env_flags === vf, "R8", "call return leaves flags", env_flags, vf);

        // R2: start while busy is ignored
        host_rf(3'd3, 16'h0080);
        run_op(1'b0, 3'd0, 3'd4, 3'd3, 1'b0, 1'b1, "R2 poke push");
        run_op(1'b1, 3'd0, 3'd4, 3'd3, 1'b0, 1'b1, "R2 poke pop");

        // R5: full-range transfers covering the stack-pointer register
        host_rf(3'd1, 16'h0020);
        run_op(1'b0, 3'd0, 3'd7, 3'd1, 1'b0, 1'b0, "R5 push covers sp");
        host_rf(3'd2, 16'h0010);
        run_op(1'b1, 3'd0, 3'd7, 3'd2, 1'b0, 1'b0, "R5 pop covers sp");

        // R3 R4: random operations
        for (int t = 0; t < 60; t++) begin
            bit p, w;
            logic [2:0] a, n, b;
            p = 1'($urandom % 2);
            w = (($urandom % 4) == 0);
            a = 3'($urandom);
            n = 3'($urandom);
            b = 3'($urandom);
            host_rf(b, 16'($urandom));
            host_rf(3'($urandom), 16'($urandom));
            if (($urandom % 3) == 0) host_flags(16'($urandom));
            run_op(p, a, n, b, w, 1'b0, p ? "R4 random pop" : "R3 random push");
        end

        finish_run();
    end

endmodule